// File: doc/BRIEF.md
# Floating-Point Exception Status Controller

This block holds the exception state of a stack-based floating-point unit. It keeps a 16-bit status word and reads the exception masks from the low six bits of a 16-bit control word. The arithmetic datapath sends it one-cycle exception reports. The divider sends it its divisor, and a divisor of zero is logged as a zero-divide exception. Instruction decode sends it three commands: clear-exceptions, initialize and wait.

A wait command checks whether an unmasked exception is pending. If none is pending, the wait completes at once. If one is pending, the controller either raises the internal numeric-fault vector or drives a legacy external error pin. A numeric-error enable input chooses between the two. If the coprocessor-monitor and task-switched flags are both set, a wait raises the device-not-available vector before anything else is checked.

All outputs are registered. A command or report presented in one cycle shows up on the outputs after the next rising clock edge.

Top module: `fpx_ctrl_top`

## Requirements
- R1: While reset is low at a clock edge, the status word becomes 0x0000, and `wait_done`, `fault_valid`, `fault_vector` and `fpe_pin` become 0.
- R2: Each report ORs `rpt_flags[6:0]` into status bits 6..0 at the next edge. The bit order is: 0 invalid, 1 denormal, 2 zero-divide, 3 overflow, 4 underflow, 5 precision, 6 stack fault. These bits stay set until a clear or an initialize.
- R3: A cycle that reports at least one flag sets status bit 7 (summary) and bit 15 (busy) when, after the OR, some status bit i in 0..5 is set while `ctrl_word[i]` is 0. If every set bit in 0..5 is masked, bits 7 and 15 are left unchanged.
- R4: When `div_valid` is high and `div_divisor` is all zeros, the controller reports zero-divide (bit 2). A divide with a nonzero divisor reports nothing.
- R5: `cmd_clear` ANDs the status word with 0x7F00. This zeroes bits 0..7 and bit 15.
- R6: `cmd_init` sets the whole status word to 0x0000. It takes priority over `cmd_clear`.
- R7: When a clear or initialize arrives in the same cycle as reports, the clear or initialize is applied first. The new flags are then ORed in, and the summary rule is evaluated on the result.
- R8: A wait with `mon_cop` and `task_sw` both high gives `fault_valid`=1 and `fault_vector`=7 at the next edge, whatever the summary bit holds. It gives no `wait_done` and leaves `fpe_pin` unchanged.
- R9: Otherwise, a wait that finds status bit 7 set while `ne_enable`=1 gives `fault_valid`=1 and `fault_vector`=16, with no `wait_done`.
- R10: Otherwise, a wait that finds status bit 7 set while `ne_enable`=0 gives a `wait_done` pulse and raises `fpe_pin`. `fpe_pin` stays high until a clear or initialize removes the summary bit, and it falls at that same edge.
- R11: Otherwise, a wait that finds status bit 7 clear gives a one-cycle `wait_done` pulse with no fault. The wait uses the status word from before any update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_word | input | 16 | Control word; bits 5..0 are exception masks (1 = masked) |
| rpt_flags | input | 7 | Exception report flags from the datapath, status bits 6..0 |
| div_valid | input | 1 | A divide is completing this cycle |
| div_divisor | input | 32 | Divisor of the completing divide |
| cmd_clear | input | 1 | Clear-exceptions command |
| cmd_init | input | 1 | Initialize command |
| cmd_wait | input | 1 | Wait command |
| ne_enable | input | 1 | Numeric-error enable: 1 selects the internal fault, 0 the external pin |
| mon_cop | input | 1 | Coprocessor-monitor flag |
| task_sw | input | 1 | Task-switched flag |
| status_word | output | 16 | Exception status word |
| wait_done | output | 1 | Wait completed without a fault |
| fault_valid | output | 1 | A fault is raised this cycle |
| fault_vector | output | 8 | Vector number of the raised fault |
| fpe_pin | output | 1 | Legacy external floating-point error output |

## Verification
The assertions assume that decode sends one command at most in each cycle, apart from the deliberate pairing of a clear or initialize with reports. They also assume the mask field is steady in a cycle that carries a report. Each bench task applies its commands as single-cycle pulses, and it changes `ctrl_word` only in idle cycles, before the report it affects. The same-cycle tests pair clear and initialize with reports only, never with a wait.

// File: rtl/fpx_pkg.sv
// Package: shared widths and bit positions of the exception status word.
// Assumes a 16-bit status word with six maskable flags plus a stack-fault flag.
package fpx_pkg;
    localparam int SW         = 16;
    localparam int MASK_W     = 6;
    localparam int FLAG_W     = MASK_W + 1;
    localparam int ZDIV_BIT   = 2;
    localparam int SUM_BIT    = 7;
    localparam int BUSY_BIT   = 15;
    localparam logic [SW-1:0] CLR_KEEP = 16'h7F00;
endpackage

// File: rtl/fpx_divzero_det.sv
// Module: turns a completing divide into a zero-divide report when the
// divisor is all zeros. Assumes div_valid is high for exactly one cycle
// per divide; the quotient path is untouched and is not delayed.
module fpx_divzero_det #(
    parameter int DW = 32
) (
    input  logic          div_valid,
    input  logic [DW-1:0] div_divisor,
    output logic          zdiv_rpt
);
    // Zero-detect on the divisor, gated by the divide-valid strobe.
    always_comb begin
        zdiv_rpt = div_valid && (div_divisor == '0);
    end
endmodule

// File: rtl/fpx_status_reg.sv
// Module: holds the status word. Applies init/clear first, then ORs the
// reported flags in, and sets summary and busy when an unmasked flag is set.
// Assumes reports are single-cycle pulses and the masks are stable with them.
module fpx_status_reg
    import fpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MASK_W-1:0] mask,
    input  logic [FLAG_W-1:0] flags_in,
    input  logic              cmd_clear,
    input  logic              cmd_init,
    output logic [SW-1:0]     status_q,
    output logic [SW-1:0]     status_d
);
    logic [SW-1:0]     base;
    logic [SW-1:0]     merged;
    logic [MASK_W-1:0] live;
    logic              any_rpt;

    // Per-flag unmasked detect, one term per maskable exception.
    for (genvar i = 0; i < MASK_W; i++) begin : g_live
        assign live[i] = merged[i] & ~mask[i];
    end

    // Next-state: init/clear first, then OR of new flags, then summary rule.
    always_comb begin
        any_rpt = |flags_in;
        if (cmd_init)       base = '0;
        else if (cmd_clear) base = status_q & CLR_KEEP;
        else                base = status_q;
        merged = base | {{(SW-FLAG_W){1'b0}}, flags_in};
        status_d = merged;
        if (any_rpt && (|live)) begin
            status_d[SUM_BIT]  = 1'b1;
            status_d[BUSY_BIT] = 1'b1;
        end
    end

    // Status register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    // R2: with no clear or init, previously set flags survive.
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_clear && !cmd_init) |=>
        ((status_q[FLAG_W-1:0] & $past(status_q[FLAG_W-1:0])) == $past(status_q[FLAG_W-1:0])));

    // R3: a report leaving an unmasked flag set raises summary and busy.
    a_r3_summary: assert property (@(posedge clk) disable iff (!rst_n)
        ((|flags_in) && !cmd_clear && !cmd_init && (|(flags_in[MASK_W-1:0] & ~mask))) |=>
        (status_q[SUM_BIT] && status_q[BUSY_BIT]));

    // R5: a lone clear empties bits 0..7 and 15 and keeps 8..14.
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_clear && !cmd_init && !(|flags_in)) |=>
        ((status_q & ~CLR_KEEP) == '0 && status_q[14:8] == $past(status_q[14:8])));

    // R6: a lone init empties the word.
    a_r6_init: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_init && !(|flags_in)) |=> (status_q == '0));
endmodule

// File: rtl/fpx_wait_ctrl.sv
// Module: resolves a wait command into completion, an internal fault or the
// external error pin, and holds that pin while the summary bit stays set.
// Assumes sum_q is the registered summary bit and sum_d its next value.
module fpx_wait_ctrl #(
    parameter int VW      = 8,
    parameter int VEC_DNA = 7,
    parameter int VEC_NM  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wait,
    input  logic          mon_cop,
    input  logic          task_sw,
    input  logic          ne_enable,
    input  logic          sum_q,
    input  logic          sum_d,
    output logic          wait_done,
    output logic          fault_valid,
    output logic [VW-1:0] fault_vector,
    output logic          fpe_pin
);
    localparam logic [VW-1:0] DNA_V = VW'(VEC_DNA);
    localparam logic [VW-1:0] NM_V  = VW'(VEC_NM);

    logic          dna_hit;
    logic          nm_hit;
    logic          pin_hit;
    logic          done_d;
    logic          flt_d;
    logic [VW-1:0] vec_d;
    logic          pin_d;

    // Priority decode: device-not-available, then internal fault, then pin.
    always_comb begin
        dna_hit = cmd_wait && mon_cop && task_sw;
        nm_hit  = cmd_wait && !dna_hit && sum_q && ne_enable;
        pin_hit = cmd_wait && !dna_hit && sum_q && !ne_enable;
        done_d  = cmd_wait && !dna_hit && !nm_hit;
        flt_d   = dna_hit || nm_hit;
        vec_d   = dna_hit ? DNA_V : (nm_hit ? NM_V : '0);
        pin_d   = (fpe_pin || pin_hit) && sum_d;
    end

    // Registered wait results and the latched error pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_done    <= 1'b0;
            fault_valid  <= 1'b0;
            fault_vector <= '0;
            fpe_pin      <= 1'b0;
        end else begin
            wait_done    <= done_d;
            fault_valid  <= flt_d;
            fault_vector <= vec_d;
            fpe_pin      <= pin_d;
        end
    end

    // R8: both flags set on a wait gives vector 7 and no completion.
    a_r8_dna: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wait && mon_cop && task_sw) |=>
        (fault_valid && fault_vector == DNA_V && !wait_done));

    // R9: pending summary with numeric-error enable gives vector 16.
    a_r9_numeric: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wait && !(mon_cop && task_sw) && sum_q && ne_enable) |=>
        (fault_valid && fault_vector == NM_V && !wait_done));

    // R10: the external pin is only ever high while summary is set.
    a_r10_pin_needs_sum: assert property (@(posedge clk) disable iff (!rst_n)
        fpe_pin |-> sum_q);

    // R11: completion and fault never coincide.
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wait_done && fault_valid));
endmodule

// File: rtl/fpx_ctrl_top.sv
// Module: top of the floating-point exception status controller. Joins the
// divide zero-detect, the status register and the wait resolver.
// Assumes one command per cycle from decode; reports may pair with clear/init.
module fpx_ctrl_top
    import fpx_pkg::*;
#(
    parameter int DW      = 32,
    parameter int VW      = 8,
    parameter int VEC_DNA = 7,
    parameter int VEC_NM  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SW-1:0]     ctrl_word,
    input  logic [FLAG_W-1:0] rpt_flags,
    input  logic              div_valid,
    input  logic [DW-1:0]     div_divisor,
    input  logic              cmd_clear,
    input  logic              cmd_init,
    input  logic              cmd_wait,
    input  logic              ne_enable,
    input  logic              mon_cop,
    input  logic              task_sw,
    output logic [SW-1:0]     status_word,
    output logic              wait_done,
    output logic              fault_valid,
    output logic [VW-1:0]     fault_vector,
    output logic              fpe_pin
);
    logic              zdiv_rpt;
    logic [FLAG_W-1:0] flags_all;
    logic [SW-1:0]     status_d;
    logic              ctrl_unused;

    // Only the mask field of the control word is consumed here.
    assign ctrl_unused = ^ctrl_word[SW-1:MASK_W];

    fpx_divzero_det #(.DW(DW)) divz_i (
        .div_valid  (div_valid),
        .div_divisor(div_divisor),
        .zdiv_rpt   (zdiv_rpt)
    );

    // Merge the divider's zero-divide report with the datapath reports.
    always_comb begin
        flags_all = rpt_flags;
        flags_all[ZDIV_BIT] = rpt_flags[ZDIV_BIT] | zdiv_rpt;
    end

    fpx_status_reg stat_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mask     (ctrl_word[MASK_W-1:0]),
        .flags_in (flags_all),
        .cmd_clear(cmd_clear),
        .cmd_init (cmd_init),
        .status_q (status_word),
        .status_d (status_d)
    );

    fpx_wait_ctrl #(.VW(VW), .VEC_DNA(VEC_DNA), .VEC_NM(VEC_NM)) wait_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wait    (cmd_wait),
        .mon_cop     (mon_cop),
        .task_sw     (task_sw),
        .ne_enable   (ne_enable),
        .sum_q       (status_word[SUM_BIT]),
        .sum_d       (status_d[SUM_BIT]),
        .wait_done   (wait_done),
        .fault_valid (fault_valid),
        .fault_vector(fault_vector),
        .fpe_pin     (fpe_pin)
    );

    // R4: a zero divisor on a valid divide lands in the zero-divide flag.
    a_r4_divzero: assert property (@(posedge clk) disable iff (!rst_n)
        (div_valid && div_divisor == '0) |=> status_word[ZDIV_BIT]);
endmodule

// File: tb/fpx_ctrl_top_tb_top.sv
module fpx_ctrl_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] ctrl_word;
    logic [6:0]  rpt_flags;
    logic        div_valid;
    logic [31:0] div_divisor;
    logic        cmd_clear, cmd_init, cmd_wait;
    logic        ne_enable, mon_cop, task_sw;
    logic [15:0] status_word;
    logic        wait_done, fault_valid, fpe_pin;
    logic [7:0]  fault_vector;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;  // 250 MHz

    fpx_ctrl_top dut_i (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .rpt_flags(rpt_flags),
        .div_valid(div_valid), .div_divisor(div_divisor), .cmd_clear(cmd_clear),
        .cmd_init(cmd_init), .cmd_wait(cmd_wait), .ne_enable(ne_enable),
        .mon_cop(mon_cop), .task_sw(task_sw), .status_word(status_word),
        .wait_done(wait_done), .fault_valid(fault_valid),
        .fault_vector(fault_vector), .fpe_pin(fpe_pin)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        rpt_flags = '0; div_valid = 0; div_divisor = '0;
        cmd_clear = 0; cmd_init = 0; cmd_wait = 0;
    endtask

    // Apply the driven inputs for one edge, then return them to idle.
    task automatic step();
        @(posedge clk); #1;
        idle_inputs();
    endtask

    task automatic report(input logic [6:0] f);
        @(negedge clk); rpt_flags = f; step();
    endtask

    task automatic do_init();
        @(negedge clk); cmd_init = 1; step();
    endtask

    task automatic do_clear();
        @(negedge clk); cmd_clear = 1; step();
    endtask

    task automatic do_wait(input logic ne, input logic mp, input logic ts);
        @(negedge clk); ne_enable = ne; mon_cop = mp; task_sw = ts; cmd_wait = 1; step();
    endtask

    task automatic t_reset();
        check("R1 status", status_word, 16'h0000);
        check("R1 outputs", {wait_done, fault_valid, fault_vector, fpe_pin}, '0);
    endtask

    task automatic t_sticky();
        do_init();
        ctrl_word = 16'h037F;
        report(7'h01);
        check("R2 first flag", status_word, 16'h0001);
        report(7'h60);
        check("R2 accumulate", status_word, 16'h0061);
        repeat (3) @(posedge clk); #1;
        check("R2 sticky", status_word, 16'h0061);
    endtask

    task automatic t_summary();
        do_init();
        ctrl_word = 16'h037F;
        report(7'h24);
        check("R3 all masked", status_word, 16'h0024);
        @(negedge clk); ctrl_word = 16'h037B;
        report(7'h01);
        check("R3 unmasked older flag", status_word, 16'h80A5);
    endtask

    task automatic t_divzero();
        do_init();
        ctrl_word = 16'h037F;
        @(negedge clk); div_valid = 1; div_divisor = 32'h0000_0100; step();
        check("R4 nonzero divisor", status_word, 16'h0000);
        @(negedge clk); ctrl_word = 16'h037B; div_valid = 1; div_divisor = '0; step();
        check("R4 zero divisor", status_word, 16'h8084);
        @(negedge clk); ctrl_word = 16'h037F;
    endtask

    task automatic t_clear_init();
        do_init();
        ctrl_word = 16'h0370;
        report(7'h4F);
        check("R5 setup", status_word, 16'h80CF);
        do_clear();
        check("R5 clear", status_word, 16'h0000);
        report(7'h03);
        do_init();
        check("R6 init", status_word, 16'h0000);
        @(negedge clk); cmd_init = 1; cmd_clear = 1; step();
        check("R6 init over clear", status_word, 16'h0000);
    endtask

    task automatic t_same_cycle();
        do_init();
        @(negedge clk); ctrl_word = 16'h037B;
        report(7'h04);
        check("R7 setup", status_word, 16'h8084);
        @(negedge clk); cmd_clear = 1; rpt_flags = 7'h08; step();
        check("R7 clear then masked report", status_word, 16'h0008);
        @(negedge clk); cmd_init = 1; rpt_flags = 7'h04; step();
        check("R7 init then unmasked report", status_word, 16'h8084);
    endtask

    task automatic t_wait_dna();
        do_wait(1, 1, 1);
        check("R8 fault", {fault_valid, fault_vector}, {1'b1, 8'd7});
        check("R8 no done", wait_done, 1'b0);
        check("R8 pin", fpe_pin, 1'b0);
        do_init();
        do_wait(0, 1, 1);
        check("R8 no summary", {fault_valid, fault_vector, wait_done}, {1'b1, 8'd7, 1'b0});
        mon_cop = 0; task_sw = 0;
    endtask

    task automatic t_wait_numeric();
        do_init();
        @(negedge clk); ctrl_word = 16'h037B;
        report(7'h04);
        do_wait(1, 1, 0);
        check("R9 fault", {fault_valid, fault_vector, wait_done}, {1'b1, 8'd16, 1'b0});
        check("R9 pin", fpe_pin, 1'b0);
        @(posedge clk); #1;
        check("R9 single pulse", fault_valid, 1'b0);
    endtask

    task automatic t_wait_pin();
        do_init();
        @(negedge clk); ctrl_word = 16'h037B;
        report(7'h04);
        do_wait(0, 0, 0);
        check("R10 done and pin", {wait_done, fault_valid, fpe_pin}, 3'b101);
        repeat (2) @(posedge clk); #1;
        check("R10 pin held", fpe_pin, 1'b1);
        report(7'h01);
        check("R10 pin held over report", fpe_pin, 1'b1);
        do_clear();
        check("R10 pin falls on clear", fpe_pin, 1'b0);
        report(7'h04);
        do_wait(0, 0, 0);
        do_init();
        check("R10 pin falls on init", fpe_pin, 1'b0);
    endtask

    task automatic t_wait_clean();
        do_init();
        @(negedge clk); ctrl_word = 16'h037B;
        do_wait(1, 0, 0);
        check("R11 done", {wait_done, fault_valid, fpe_pin}, 3'b100);
        @(posedge clk); #1;
        check("R11 one cycle", wait_done, 1'b0);
        @(negedge clk); cmd_wait = 1; ne_enable = 1; rpt_flags = 7'h04; step();
        check("R11 old status used", {wait_done, fault_valid}, 2'b10);
        check("R11 status updated", status_word, 16'h8084);
    endtask

    initial begin
        rst_n = 0; ctrl_word = 16'h037F; ne_enable = 0; mon_cop = 0; task_sw = 0;
        idle_inputs();
        repeat (4) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst_n = 1;
        t_sticky();
        t_summary();
        t_divzero();
        t_clear_init();
        t_same_cycle();
        t_wait_dna();
        t_wait_numeric();
        t_wait_pin();
        t_wait_clean();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: actual hung expected finish");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule